// File: doc/BRIEF.md
# Background Block-Store Buffer Pool

This block lets a core launch block fill operations and carry on executing while the fills drain to memory on their own. An issue request carries a start address, a word count and a 64-bit fill value. The block copies all three into a free buffer in the same cycle and answers with a handle at once. From then on, the core's registers play no further part in the operation.

Each active buffer writes its fill value to consecutive 8-byte words. Stores go out one at a time through a shared memory request port, and only in cycles when the memory side says it is not busy. Several active buffers share the port in rotating order. Interrupts are not wired to any of this: a running fill keeps going.

Software, or the core, reaches an operation only through its handle. A status query returns the buffer's state and how many words remain. A cancel request stops the operation before its next store. A finished or cancelled buffer stays readable until a later issue reuses it.

Top module: `bgstore_pool`

## Requirements
- R1: After reset every buffer reads state 0 (idle) with 0 words remaining, and no memory request is raised.
- R2: An issue is accepted in the same cycle (`iss_ok`) whenever some buffer is not in state 1 (active). The handle returned is the lowest such index. Address, count and fill value are captured in that cycle, and later changes on the issue inputs do not affect the operation.
- R3: When all buffers are active, an issue raises `iss_full` instead of `iss_ok`, and no buffer changes.
- R4: `mem_req_valid` is never high while `mem_busy` is high. Every cycle with `mem_req_valid` high and `mem_busy` low counts as one accepted store.
- R5: For a capture with address A, count N and value D, the buffer issues exactly N stores, at addresses A, A+8, …, A+8(N-1), each carrying data D and its handle on `mem_req_tag`.
- R6: When the last store is accepted, the buffer moves to state 2 (done) with 0 remaining and requests nothing more.
- R7: An issue with count 0 is accepted and goes to state 2 (done) on the next cycle, without any memory request.
- R8: While several buffers are active, each accepted store is granted to the first eligible buffer after the one granted last, in increasing index order with wrap-around. After reset the search starts at index 0.
- R9: The status outputs show the state (0 idle, 1 active, 2 done, 3 cancelled) and the remaining word count of the buffer selected by `qry_handle`, in the same cycle.
- R10: A cancel aimed at an active buffer stops it before any further store, including a store in the cancel cycle itself. The buffer moves to state 3 and keeps its remaining count. A cancel aimed at a buffer that is not active has no effect.
- R11: The `irq` input has no effect on issue, stores, status or cancel.
- R12: A buffer in state 2 or 3 can be allocated again by a new issue, which overwrites its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_addr | input | AW | Start byte address |
| iss_count | input | CW | Number of words to store |
| iss_data | input | DW | Fill value |
| iss_ok | output | 1 | Issue accepted; handle valid |
| iss_full | output | 1 | Issue refused, no free buffer |
| iss_handle | output | log2(NBUF) | Handle of the allocated buffer |
| irq | input | 1 | Interrupt indication, ignored |
| qry_handle | input | log2(NBUF) | Buffer selected for status |
| qry_state | output | 2 | State of the selected buffer |
| qry_remaining | output | CW | Words still to store |
| cxl_valid | input | 1 | Cancel request |
| cxl_handle | input | log2(NBUF) | Buffer to cancel |
| mem_busy | input | 1 | Memory unit busy; blocks requests |
| mem_req_valid | output | 1 | Store request, accepted when raised |
| mem_req_addr | output | AW | Store address |
| mem_req_data | output | DW | Store data |
| mem_req_tag | output | log2(NBUF) | Buffer issuing the store |

## Verification
Directed runs come first. Single operations of count 0 and 2 separate immediate completion from a real drain. Filling all four buffers while the port is held busy separates the full refusal from a normal allocation. Draining four buffers at once with `irq` toggling exposes the grant rotation and shows that interrupts have no effect. A cancel placed in a cycle that would otherwise store shows that cancel wins over the grant, and cancels aimed at done or idle buffers show that nothing changes. A long seeded random phase then mixes issue, cancel, busy, interrupt and query patterns, which reaches buffer reuse and grant wrap-around in many orders.

// File: rtl/bgstore_pool.sv
module bgstore_pool #(
  parameter int NBUF       = 4,
  parameter int AW         = 32,
  parameter int CW         = 16,
  parameter int DW         = 64,
  parameter int WORD_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    iss_valid,
  input  logic [AW-1:0]           iss_addr,
  input  logic [CW-1:0]           iss_count,
  input  logic [DW-1:0]           iss_data,
  output logic                    iss_ok,
  output logic                    iss_full,
  output logic [$clog2(NBUF)-1:0] iss_handle,
  input  logic                    irq,
  input  logic [$clog2(NBUF)-1:0] qry_handle,
  output logic [1:0]              qry_state,
  output logic [CW-1:0]           qry_remaining,
  input  logic                    cxl_valid,
  input  logic [$clog2(NBUF)-1:0] cxl_handle,
  input  logic                    mem_busy,
  output logic                    mem_req_valid,
  output logic [AW-1:0]           mem_req_addr,
  output logic [DW-1:0]           mem_req_data,
  output logic [$clog2(NBUF)-1:0] mem_req_tag
);
  localparam int HW = $clog2(NBUF);
  localparam logic [1:0] ST_IDLE = 2'd0, ST_ACT = 2'd1, ST_DONE = 2'd2, ST_CXL = 2'd3;
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  logic [NBUF-1:0][1:0]    st_q;
  logic [NBUF-1:0][CW-1:0] rem_q;
  logic [NBUF-1:0][AW-1:0] addr_q;
  logic [NBUF-1:0][DW-1:0] data_q;
  logic [HW-1:0]           rr_q;

  logic          free_found, gnt_found;
  logic [HW-1:0] free_idx, gnt_idx;
  logic [NBUF-1:0] elig;

  logic unused_irq;
  assign unused_irq = irq;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (st_q[i] != ST_ACT) begin
        free_found = 1'b1;
        free_idx   = HW'(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NBUF; i++)
      elig[i] = (st_q[i] == ST_ACT) && !(cxl_valid && cxl_handle == HW'(i));
  end

  always_comb begin
    gnt_found = 1'b0;
    gnt_idx   = '0;
    for (int k = NBUF - 1; k >= 0; k--) begin
      if (elig[(int'(rr_q) + 1 + k) % NBUF]) begin
        gnt_found = 1'b1;
        gnt_idx   = HW'((int'(rr_q) + 1 + k) % NBUF);
      end
    end
  end

  assign iss_ok        = iss_valid && free_found;
  assign iss_full      = iss_valid && !free_found;
  assign iss_handle    = free_idx;
  assign qry_state     = st_q[qry_handle];
  assign qry_remaining = rem_q[qry_handle];
  assign mem_req_valid = gnt_found && !mem_busy;
  assign mem_req_addr  = addr_q[gnt_idx];
  assign mem_req_data  = data_q[gnt_idx];
  assign mem_req_tag   = gnt_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= '0;
      rem_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      rr_q   <= HW'(NBUF - 1);
    end else begin
      if (mem_req_valid) rr_q <= gnt_idx;
      for (int i = 0; i < NBUF; i++) begin
        if (mem_req_valid && gnt_idx == HW'(i)) begin
          addr_q[i] <= addr_q[i] + STEP;
          rem_q[i]  <= rem_q[i] - 1'b1;
          if (rem_q[i] == CW'(1)) st_q[i] <= ST_DONE;
        end
        if (cxl_valid && cxl_handle == HW'(i) && st_q[i] == ST_ACT)
          st_q[i] <= ST_CXL;
        if (iss_ok && free_idx == HW'(i)) begin
          addr_q[i] <= iss_addr;
          rem_q[i]  <= iss_count;
          data_q[i] <= iss_data;
          st_q[i]   <= (iss_count == '0) ? ST_DONE : ST_ACT;
        end
      end
    end
  end
endmodule

module bgstore_pool_chk #(
  parameter int NBUF = 4,
  parameter int CW   = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    iss_ok,
  input logic                    iss_full,
  input logic [CW-1:0]           iss_count,
  input logic [$clog2(NBUF)-1:0] iss_handle,
  input logic                    cxl_valid,
  input logic [$clog2(NBUF)-1:0] cxl_handle,
  input logic                    mem_busy,
  input logic                    mem_req_valid,
  input logic [$clog2(NBUF)-1:0] mem_req_tag,
  input logic [NBUF-1:0][1:0]    st_q,
  input logic [NBUF-1:0][CW-1:0] rem_q
);
  // R4
  no_req_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_busy |-> !mem_req_valid);
  // R3
  full_refuses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_full |-> !iss_ok);
  // R2
  alloc_not_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_ok |-> st_q[iss_handle] != 2'd1);
  // R5
  req_from_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> st_q[mem_req_tag] == 2'd1);
  // R6
  last_store_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && rem_q[mem_req_tag] == CW'(1)) |=> st_q[$past(mem_req_tag)] == 2'd2);
  // R7
  zero_count_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_ok && iss_count == '0) |=> st_q[$past(iss_handle)] == 2'd2);
  // R10
  cancel_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cxl_valid && st_q[cxl_handle] == 2'd1) |=> st_q[$past(cxl_handle)] == 2'd3);
endmodule

bind bgstore_pool bgstore_pool_chk #(.NBUF(NBUF), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_ok(iss_ok), .iss_full(iss_full),
  .iss_count(iss_count), .iss_handle(iss_handle), .cxl_valid(cxl_valid),
  .cxl_handle(cxl_handle), .mem_busy(mem_busy), .mem_req_valid(mem_req_valid),
  .mem_req_tag(mem_req_tag), .st_q(st_q), .rem_q(rem_q)
);

// File: tb/bgstore_pool_bench.sv
module bgstore_pool_bench;
  localparam int AW = 32, CW = 16, DW = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic iss_valid = 0, cxl_valid = 0, mem_busy = 0, irq = 0;
  logic [AW-1:0] iss_addr = '0;
  logic [CW-1:0] iss_count = '0;
  logic [DW-1:0] iss_data = '0;
  logic [1:0] qry_handle = '0, cxl_handle = '0;
  logic iss_ok, iss_full, mem_req_valid;
  logic [1:0] iss_handle, qry_state, mem_req_tag;
  logic [CW-1:0] qry_remaining;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_data;

  always #5 clk = ~clk;

  bgstore_pool u_bgstore_pool (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_addr(iss_addr),
    .iss_count(iss_count), .iss_data(iss_data), .iss_ok(iss_ok), .iss_full(iss_full),
    .iss_handle(iss_handle), .irq(irq), .qry_handle(qry_handle), .qry_state(qry_state),
    .qry_remaining(qry_remaining), .cxl_valid(cxl_valid), .cxl_handle(cxl_handle),
    .mem_busy(mem_busy), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_data(mem_req_data), .mem_req_tag(mem_req_tag)
  );

  int n_chk = 0, n_fail = 0;
  string itag = "R2", rtag = "R5", qtag = "R9";

  logic [1:0]    m_st   [4];
  logic [CW-1:0] m_rem  [4];
  logic [AW-1:0] m_addr [4];
  logic [DW-1:0] m_data [4];
  logic [1:0]    m_rr;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int find_free();
    for (int i = 0; i < 4; i++) if (m_st[i] != 2'd1) return i;
    return -1;
  endfunction

  function automatic int find_grant();
    for (int k = 1; k <= 4; k++) begin
      int c = (int'(m_rr) + k) % 4;
      if (m_st[c] == 2'd1 && !(cxl_valid && cxl_handle == 2'(c))) return c;
    end
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_st[i] = 0; m_rem[i] = 0; m_addr[i] = 0; m_data[i] = 0;
    end
    m_rr = 2'd3;
  endtask

  task automatic step(input bit iv, input logic [AW-1:0] a, input logic [CW-1:0] c,
                      input logic [DW-1:0] d, input bit cv, input logic [1:0] ch,
                      input bit busy, input bit ir, input logic [1:0] qh);
    int fr, g;
    bit e_req;
    @(negedge clk);
    iss_valid = iv; iss_addr = a; iss_count = c; iss_data = d;
    cxl_valid = cv; cxl_handle = ch; mem_busy = busy; irq = ir; qry_handle = qh;
    #1;
    fr = find_free();
    g  = find_grant();
    e_req = !busy && g >= 0;
    chk(iss_ok == (iv && fr >= 0), itag, "iss_ok", 64'(iss_ok), 64'(iv && fr >= 0));
    chk(iss_full == (iv && fr < 0), itag == "R2" ? "R3" : itag, "iss_full", 64'(iss_full), 64'(iv && fr < 0));
    if (iv && fr >= 0)
      chk(iss_handle == 2'(fr), itag, "iss_handle", 64'(iss_handle), 64'(fr));
    chk(mem_req_valid == e_req, busy ? "R4" : rtag, "mem_req_valid", 64'(mem_req_valid), 64'(e_req));
    if (e_req) begin
      chk(mem_req_tag == 2'(g), rtag == "R5" ? "R8" : rtag, "mem_req_tag", 64'(mem_req_tag), 64'(g));
      chk(mem_req_addr == m_addr[g], rtag, "mem_req_addr", 64'(mem_req_addr), 64'(m_addr[g]));
      chk(mem_req_data == m_data[g], rtag, "mem_req_data", mem_req_data, m_data[g]);
    end
    chk(qry_state == m_st[qh], qtag, "qry_state", 64'(qry_state), 64'(m_st[qh]));
    chk(qry_remaining == m_rem[qh], qtag, "qry_remaining", 64'(qry_remaining), 64'(m_rem[qh]));
    @(posedge clk);
    if (!rst_n) model_reset();
    else begin
      if (e_req) begin
        m_rr = 2'(g);
        m_addr[g] = m_addr[g] + 8;
        m_rem[g]  = m_rem[g] - 1;
        if (m_rem[g] == 0) m_st[g] = 2'd2;
      end
      if (cv && m_st[ch] == 2'd1) m_st[ch] = 2'd3;
      if (iv && fr >= 0) begin
        m_addr[fr] = a; m_rem[fr] = c; m_data[fr] = d;
        m_st[fr] = (c == 0) ? 2'd2 : 2'd1;
      end
    end
  endtask

  task automatic idle(input bit busy, input logic [1:0] qh);
    step(0, '0, '0, '0, 0, 2'd0, busy, 0, qh);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state of every buffer
    qtag = "R1"; rtag = "R1";
    for (int h = 0; h < 4; h++) idle(0, 2'(h));

    // R7: zero-count completes without a request
    qtag = "R7"; rtag = "R7";
    step(1, 32'h100, 0, 64'hAAAA, 0, 0, 0, 0, 0);
    idle(0, 0);
    idle(0, 0);

    // R12: done buffer 0 reused; R2 capture then inputs change
    itag = "R12"; qtag = "R12";
    step(1, 32'h2000, 2, 64'hDEAD_BEEF_0000_0001, 0, 0, 1, 0, 0);
    itag = "R2"; qtag = "R2";
    step(0, 32'hFFFF_FFF0, 9, 64'h1, 0, 0, 1, 0, 0);
    // R4: busy held, buffers 1..3 filled
    step(1, 32'h3000, 3, 64'h33, 0, 0, 1, 0, 1);
    step(1, 32'h4000, 3, 64'h44, 0, 0, 1, 0, 2);
    step(1, 32'h5000, 3, 64'h55, 0, 0, 1, 0, 3);
    // R3: all active, refused
    itag = "R3";
    step(1, 32'h6000, 3, 64'h66, 0, 0, 1, 0, 0);
    chk(m_st[0] == 2'd1, "R3", "buffer0 state after refusal", 64'(m_st[0]), 64'd1);
    itag = "R2";

    // R8 and R11: drain with rotation while irq toggles; R6 completion
    rtag = "R8"; qtag = "R6";
    for (int i = 0; i < 14; i++) step(0, 0, 0, 0, 0, 0, 0, i[0], 2'(i % 4));
    rtag = "R11";
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 0, 1, 2'(i));
    chk(qry_state == 2'd2, "R6", "state after drain", 64'(qry_state), 64'd2);

    // R10: cancel in a would-be store cycle, then no further stores
    rtag = "R10"; qtag = "R10";
    step(1, 32'h8000, 5, 64'h77, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) idle(0, 0);
    chk(m_rem[0] == 4 && m_st[0] == 2'd3, "R10", "model cancelled count", 64'(m_rem[0]), 64'd4);
    step(0, 0, 0, 0, 1, 1, 0, 0, 1);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0);
    idle(0, 1);

    // R5/R9: seeded random traffic
    itag = "R2"; rtag = "R5"; qtag = "R9";
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) == 0, $urandom, CW'($urandom % 7), {$urandom, $urandom},
           ($urandom % 10) == 0, 2'($urandom), ($urandom % 3) == 0, $urandom % 2,
           2'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule